// File: doc/BRIEF.md
# Three-Stage Integer Multiply Unit

This block is a pipelined integer multiplier for a processor execution lane. It accepts two `XLEN`-bit operands, an opcode that picks the low word, the high word, or the high half of a narrow product, a flag that marks the operation as signed, and a flag that selects 32-bit mode. Three cycles later it returns the chosen result. With the result it returns two write-enable qualifiers: one for the destination register and one for the overflow register.

Signed operations use sign and magnitude. The first stage replaces each operand with its absolute value and records whether the operand signs differ. The second stage multiplies the two unsigned magnitudes. The third stage negates the product when the signs differed, takes the requested slice, and computes the overflow bit. Overflow is set when the upper product bits are not a pure sign extension. The instruction's overflow-enable bit is not applied here; a later output stage gates the overflow write with it.

The pipeline accepts one operation per cycle and has no stall path. The default parameters describe a 64-bit unit, and the width is a parameter.

Top module: `mul3_unit`

## Requirements
- R1: An operation presented with `in_valid` high appears on the outputs exactly three clock cycles later with `out_valid` high. A cycle with `in_valid` low appears three cycles later with `out_valid` low. A new operation may enter on every cycle.
- R2: While `rst` is high at a rising edge, every stage is cleared. After that edge `out_valid`, `out_res`, `out_res_ok`, `out_ovf` and `out_ovf_ok` all read zero.
- R3: Opcode `2'b00` (low word), with `in_w32` low, returns bits [XLEN-1:0] of the full product. For this opcode, `in_signed` high treats both operands as two's complement and `in_signed` low treats them as unsigned. This includes the most negative value times minus one, zero operands and all-ones operands.
- R4: Opcode `2'b01` (high word) returns bits [2*XLEN-1:XLEN] of the 2*XLEN-bit signed or unsigned product of the full operands, whatever the value of `in_w32`.
- R5: Opcode `2'b10` (high half) multiplies the low XLEN/2 bits of each operand. When signed, it takes each sign from bit XLEN/2-1. It returns bits [XLEN-1:XLEN/2] of that product, copied into both halves of `out_res`. This opcode is legal only with `in_w32` high.
- R6: Opcode `2'b00` with `in_w32` high sign-extends or zero-extends the low XLEN/2 bits of each operand before multiplying. Its overflow bit is set when product bits [XLEN-1:XLEN/2-1] are neither all zeros nor all ones.
- R7: Opcode `2'b00` with `in_w32` low sets `out_ovf` when product bits [2*XLEN-1:XLEN-1] are neither all zeros nor all ones.
- R8: `out_res_ok` is high only for a valid operation with a recognised opcode. Opcode `2'b11`, and opcode `2'b10` with `in_w32` low, are unrecognised. They give `out_valid` high with `out_res_ok` low, `out_ovf_ok` low and `out_res` zero. `out_res` is zero whenever `out_res_ok` is low.
- R9: `out_ovf_ok` is high only for a valid recognised low-word operation. `out_ovf` is zero whenever `out_ovf_ok` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_a | input | XLEN | First operand |
| in_b | input | XLEN | Second operand |
| in_op | input | 2 | Opcode: 00 low word, 01 high word, 10 high half, 11 unrecognised |
| in_signed | input | 1 | Treat operands as two's complement |
| in_w32 | input | 1 | 32-bit (half-width) mode |
| out_valid | output | 1 | Result slot occupied |
| out_res | output | XLEN | Selected result |
| out_res_ok | output | 1 | Result register write qualifier |
| out_ovf | output | 1 | Overflow bit |
| out_ovf_ok | output | 1 | Overflow register write qualifier |

## Verification
A fault in the first stage shows up on the outputs three cycles later. A wrong absolute value or a lost sign-difference bit gives a result that is off by a sign or a magnitude. A wrong narrowing decision corrupts only the 32-bit-mode and high-half results.

Faults in the last stage show up at the same output cycle:
- A slip in the overflow slice or the qualifier decode shows as a flipped `out_ovf` or a write qualifier on the wrong opcode.
- A valid or control bit that drifts one stage out of step with its data gives a result that belongs to a neighbouring operation.

Because every operation is compared in its own output slot, such a shift is caught on the first pair of back-to-back operations whose results differ.

// File: rtl/mul3_pkg.sv
package mul3_pkg;

    typedef enum logic [1:0] {
        MOP_LOW       = 2'b00,
        MOP_HIGH      = 2'b01,
        MOP_HIGH_HALF = 2'b10,
        MOP_RSVD      = 2'b11
    } mop_e;

endpackage

// File: rtl/mul3_abs_stage.sv
module mul3_abs_stage
    import mul3_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    input  mop_e            in_op,
    input  logic            in_signed,
    input  logic            in_w32,
    output logic            o_valid,
    output logic [XLEN-1:0] o_mag_a,
    output logic [XLEN-1:0] o_mag_b,
    output logic            o_neg,
    output mop_e            o_op,
    output logic            o_w32,
    output logic            o_known
);
    localparam int HALF = XLEN / 2;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] mag_a;
        logic [XLEN-1:0] mag_b;
        logic            neg;
        mop_e            op;
        logic            w32;
        logic            known;
    } s1_t;

    s1_t s1_d, s1_q;

    // Narrow the operand to its low half when required, extending by signedness.
    function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] v,
                                              input logic narrow,
                                              input logic sgn);
        logic [XLEN-1:0] r;
        if (narrow) r = {{HALF{sgn & v[HALF-1]}}, v[HALF-1:0]};
        else        r = v;
        return r;
    endfunction

    logic            narrow;
    logic [XLEN-1:0] ext_a, ext_b;
    logic            neg_a, neg_b;

    always_comb begin
        narrow = (in_op == MOP_HIGH_HALF) || ((in_op == MOP_LOW) && in_w32);
        ext_a  = widen(in_a, narrow, in_signed);
        ext_b  = widen(in_b, narrow, in_signed);
        neg_a  = in_signed & ext_a[XLEN-1];
        neg_b  = in_signed & ext_b[XLEN-1];

        s1_d       = s1_q;
        s1_d.valid = in_valid;
        s1_d.mag_a = neg_a ? (~ext_a + 1'b1) : ext_a;
        s1_d.mag_b = neg_b ? (~ext_b + 1'b1) : ext_b;
        s1_d.neg   = neg_a ^ neg_b;
        s1_d.op    = in_op;
        s1_d.w32   = in_w32;
        s1_d.known = (in_op != MOP_RSVD) && !((in_op == MOP_HIGH_HALF) && !in_w32);
    end

    always_ff @(posedge clk) begin
        if (rst) s1_q <= '0;
        else     s1_q <= s1_d;
    end

    assign o_valid = s1_q.valid;
    assign o_mag_a = s1_q.mag_a;
    assign o_mag_b = s1_q.mag_b;
    assign o_neg   = s1_q.neg;
    assign o_op    = s1_q.op;
    assign o_w32   = s1_q.w32;
    assign o_known = s1_q.known;

    AST_UNSIGNED_NO_NEG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_signed) |=> !o_neg); // R3

    AST_RSVD_UNKNOWN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == MOP_RSVD) |=> !o_known); // R8

endmodule

// File: rtl/mul3_mag_stage.sv
module mul3_mag_stage
    import mul3_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [XLEN-1:0]   in_mag_a,
    input  logic [XLEN-1:0]   in_mag_b,
    input  logic              in_neg,
    input  mop_e              in_op,
    input  logic              in_w32,
    input  logic              in_known,
    output logic              o_valid,
    output logic [2*XLEN-1:0] o_prod,
    output logic              o_neg,
    output mop_e              o_op,
    output logic              o_w32,
    output logic              o_known
);
    localparam int PW = 2 * XLEN;

    typedef struct packed {
        logic          valid;
        logic [PW-1:0] prod;
        logic          neg;
        mop_e          op;
        logic          w32;
        logic          known;
    } s2_t;

    s2_t s2_d, s2_q;

    always_comb begin
        s2_d       = s2_q;
        s2_d.valid = in_valid;
        s2_d.prod  = {{XLEN{1'b0}}, in_mag_a} * {{XLEN{1'b0}}, in_mag_b};
        s2_d.neg   = in_neg;
        s2_d.op    = in_op;
        s2_d.w32   = in_w32;
        s2_d.known = in_known;
    end

    always_ff @(posedge clk) begin
        if (rst) s2_q <= '0;
        else     s2_q <= s2_d;
    end

    assign o_valid = s2_q.valid;
    assign o_prod  = s2_q.prod;
    assign o_neg   = s2_q.neg;
    assign o_op    = s2_q.op;
    assign o_w32   = s2_q.w32;
    assign o_known = s2_q.known;

    AST_ZERO_FACTOR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_mag_a == '0 || in_mag_b == '0)) |=> (o_prod == '0)); // R3

endmodule

// File: rtl/mul3_fix_stage.sv
module mul3_fix_stage
    import mul3_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2*XLEN-1:0] in_prod,
    input  logic              in_neg,
    input  mop_e              in_op,
    input  logic              in_w32,
    input  logic              in_known,
    output logic              o_valid,
    output logic [XLEN-1:0]   o_res,
    output logic              o_res_ok,
    output logic              o_ovf,
    output logic              o_ovf_ok
);
    localparam int HALF = XLEN / 2;
    localparam int PW   = 2 * XLEN;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] res;
        logic            res_ok;
        logic            ovf;
        logic            ovf_ok;
    } s3_t;

    s3_t s3_d, s3_q;

    logic [PW-1:0]   sprod;
    logic [XLEN:0]   wide_top;
    logic [HALF:0]   narrow_top;
    logic            ovf_raw;
    logic            take;

    always_comb begin
        sprod      = in_neg ? (~in_prod + 1'b1) : in_prod;
        wide_top   = sprod[PW-1:XLEN-1];
        narrow_top = sprod[XLEN-1:HALF-1];
        ovf_raw    = in_w32 ? ((|narrow_top) & ~(&narrow_top))
                            : ((|wide_top)   & ~(&wide_top));
        take       = in_valid && in_known;

        s3_d        = '0;
        s3_d.valid  = in_valid;
        s3_d.res_ok = take;
        if (take) begin
            unique case (in_op)
                MOP_LOW: begin
                    s3_d.res    = sprod[XLEN-1:0];
                    s3_d.ovf_ok = 1'b1;
                    s3_d.ovf    = ovf_raw;
                end
                MOP_HIGH:      s3_d.res = sprod[PW-1:XLEN];
                MOP_HIGH_HALF: s3_d.res = {sprod[XLEN-1:HALF], sprod[XLEN-1:HALF]};
                default:       s3_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s3_q <= '0;
        else     s3_q <= s3_d;
    end

    assign o_valid  = s3_q.valid;
    assign o_res    = s3_q.res;
    assign o_res_ok = s3_q.res_ok;
    assign o_ovf    = s3_q.ovf;
    assign o_ovf_ok = s3_q.ovf_ok;

    AST_HALVES_MATCH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_known && in_op == MOP_HIGH_HALF)
        |=> (o_res[XLEN-1:HALF] == o_res[HALF-1:0])); // R5

    AST_OVOK_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
        (in_op != MOP_LOW) |=> !o_ovf_ok); // R9

    AST_UNKNOWN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_known) |=> (o_valid && !o_res_ok && o_res == '0)); // R8

endmodule

// File: rtl/mul3_unit.sv
module mul3_unit
    import mul3_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    input  logic [1:0]      in_op,
    input  logic            in_signed,
    input  logic            in_w32,
    output logic            out_valid,
    output logic [XLEN-1:0] out_res,
    output logic            out_res_ok,
    output logic            out_ovf,
    output logic            out_ovf_ok
);
    localparam int PW = 2 * XLEN;

    logic            s1_valid, s1_neg, s1_w32, s1_known;
    logic [XLEN-1:0] s1_mag_a, s1_mag_b;
    mop_e            s1_op;

    logic            s2_valid, s2_neg, s2_w32, s2_known;
    logic [PW-1:0]   s2_prod;
    mop_e            s2_op;

    mul3_abs_stage #(.XLEN(XLEN)) u_abs (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_op     (mop_e'(in_op)),
        .in_signed (in_signed),
        .in_w32    (in_w32),
        .o_valid   (s1_valid),
        .o_mag_a   (s1_mag_a),
        .o_mag_b   (s1_mag_b),
        .o_neg     (s1_neg),
        .o_op      (s1_op),
        .o_w32     (s1_w32),
        .o_known   (s1_known)
    );

    mul3_mag_stage #(.XLEN(XLEN)) u_mag (
        .clk      (clk),
        .rst      (rst),
        .in_valid (s1_valid),
        .in_mag_a (s1_mag_a),
        .in_mag_b (s1_mag_b),
        .in_neg   (s1_neg),
        .in_op    (s1_op),
        .in_w32   (s1_w32),
        .in_known (s1_known),
        .o_valid  (s2_valid),
        .o_prod   (s2_prod),
        .o_neg    (s2_neg),
        .o_op     (s2_op),
        .o_w32    (s2_w32),
        .o_known  (s2_known)
    );

    mul3_fix_stage #(.XLEN(XLEN)) u_fix (
        .clk      (clk),
        .rst      (rst),
        .in_valid (s2_valid),
        .in_prod  (s2_prod),
        .in_neg   (s2_neg),
        .in_op    (s2_op),
        .in_w32   (s2_w32),
        .in_known (s2_known),
        .o_valid  (out_valid),
        .o_res    (out_res),
        .o_res_ok (out_res_ok),
        .o_ovf    (out_ovf),
        .o_ovf_ok (out_ovf_ok)
    );

    AST_LATENCY_BUSY: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid); // R1

    AST_LATENCY_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##3 !out_valid); // R1

    AST_OK_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_res_ok |-> out_valid); // R8

    AST_OVF_GATED: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> out_ovf_ok); // R9

    AST_OVOK_IMPLIES_OK: assert property (@(posedge clk) disable iff (rst)
        out_ovf_ok |-> out_res_ok); // R9

endmodule

// File: tb/test_mul3_unit.sv
module test_mul3_unit;
    localparam int W = 8;
    localparam int H = W / 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic [1:0]   in_op = 2'b00;
    logic         in_signed = 1'b0;
    logic         in_w32 = 1'b0;
    logic         out_valid, out_res_ok, out_ovf, out_ovf_ok;
    logic [W-1:0] out_res;

    always #5 clk = ~clk;

    mul3_unit #(.XLEN(W)) i_mul3_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_op(in_op), .in_signed(in_signed), .in_w32(in_w32),
        .out_valid(out_valid), .out_res(out_res), .out_res_ok(out_res_ok),
        .out_ovf(out_ovf), .out_ovf_ok(out_ovf_ok)
    );

    typedef struct packed {
        logic         v;
        logic [W-1:0] r;
        logic         ok;
        logic         ov;
        logic         ovok;
        logic [1:0]   op;
        logic         w32;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    function automatic exp_t model(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [1:0] op, input logic sg, input logic w32);
        exp_t e;
        logic [2*W-1:0] ea, eb, full;
        logic [W:0]     wtop;
        logic [H:0]     ntop;
        e = '0;
        e.v = v; e.op = op; e.w32 = w32;
        if (!v) return e;
        if (op == 2'b11 || (op == 2'b10 && !w32)) return e;
        if (op == 2'b10 || (op == 2'b00 && w32)) begin
            ea = {{(2*W-H){sg & a[H-1]}}, a[H-1:0]};
            eb = {{(2*W-H){sg & b[H-1]}}, b[H-1:0]};
        end else begin
            ea = {{W{sg & a[W-1]}}, a};
            eb = {{W{sg & b[W-1]}}, b};
        end
        full = ea * eb;
        e.ok = 1'b1;
        case (op)
            2'b00: begin
                e.r = full[W-1:0];
                e.ovok = 1'b1;
                wtop = full[2*W-1:W-1];
                ntop = full[W-1:H-1];
                if (w32) e.ov = (ntop != '0) && (ntop != '1);
                else     e.ov = (wtop != '0) && (wtop != '1);
            end
            2'b01:   e.r = full[2*W-1:W];
            default: e.r = {full[W-1:H], full[W-1:H]};
        endcase
        return e;
    endfunction

    function automatic string res_tag(input exp_t e);
        if (!e.v)              return "R2";
        if (!e.ok)             return "R8";
        if (e.op == 2'b01)     return "R4";
        if (e.op == 2'b10)     return "R5";
        if (e.w32)             return "R6";
        return "R3";
    endfunction

    task automatic compare(input exp_t e);
        bit bad = 0;
        n_cmp++;
        if (out_valid !== e.v) begin
            bad = 1; $display("FAIL R1 valid: actual %b expected %b", out_valid, e.v);
        end
        if (out_res !== e.r) begin
            bad = 1; $display("FAIL %s result: actual %h expected %h", res_tag(e), out_res, e.r);
        end
        if (out_res_ok !== e.ok) begin
            bad = 1; $display("FAIL R8 res_ok: actual %b expected %b", out_res_ok, e.ok);
        end
        if (out_ovf_ok !== e.ovok) begin
            bad = 1; $display("FAIL R9 ovf_ok: actual %b expected %b", out_ovf_ok, e.ovok);
        end
        if (out_ovf !== e.ov) begin
            bad = 1;
            $display("FAIL %s overflow: actual %b expected %b", e.w32 ? "R6" : "R7", out_ovf, e.ov);
        end
        if (bad) n_bad++;
    endtask

    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [1:0] op, input logic sg, input logic w32);
        @(negedge clk);
        compare(q.pop_front());
        in_valid = v; in_a = a; in_b = b; in_op = op; in_signed = sg; in_w32 = w32;
        q.push_back(model(v, a, b, op, sg, w32));
    endtask

    task automatic check_cleared();
        n_cmp++;
        if (out_valid !== 1'b0 || out_res !== '0 || out_res_ok !== 1'b0 ||
            out_ovf !== 1'b0 || out_ovf_ok !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 reset: actual v=%b r=%h ok=%b ov=%b ovok=%b expected all zero",
                     out_valid, out_res, out_res_ok, out_ovf, out_ovf_ok);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (2) begin
            @(negedge clk);
            check_cleared();
        end
        rst = 1'b0;
        q.delete();
        repeat (3) q.push_back(model(1'b0, '0, '0, 2'b00, 1'b0, 1'b0));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [1:0] cfg_op[10] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b10, 2'b11};
        logic       cfg_sg[10] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
        logic       cfg_w [10] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
        logic [W-1:0] corner[6] = '{8'h80, 8'hFF, 8'h00, 8'h01, 8'h7F, 8'h08};
        int n = 0;

        // R2: outputs cleared while reset is held from time zero
        repeat (3) @(negedge clk);
        check_cleared();
        rst = 1'b0;
        repeat (3) q.push_back(model(1'b0, '0, '0, 2'b00, 1'b0, 1'b0));

        // Corner operands (R3, R4, R5, R6, R7): most negative, minus one, zero, all ones
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                for (int c = 0; c < 10; c++)
                    step(1'b1, corner[i], corner[j], cfg_op[c], cfg_sg[c], cfg_w[c]);

        // R2: reset with operations in flight
        step(1'b1, 8'h80, 8'hFF, 2'b00, 1'b1, 1'b0);
        step(1'b1, 8'h7F, 8'h7F, 2'b01, 1'b0, 1'b0);
        do_reset();

        // Near-exhaustive sweep per configuration, with periodic bubbles (R1)
        for (int c = 0; c < 10; c++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 5) begin
                    n++;
                    if (n % 97 == 0) step(1'b0, 8'(a), 8'(b), cfg_op[c], cfg_sg[c], cfg_w[c]);
                    step(1'b1, 8'(a), 8'(b), cfg_op[c], cfg_sg[c], cfg_w[c]);
                end

        // Drain the pipeline
        repeat (4) step(1'b0, '0, '0, 2'b00, 1'b0, 1'b0);
        finish_run();
    end
endmodule